// File: doc/BRIEF.md
# Bus Cycle Timeout Terminator

This block sits beside a processor's external bus and watches for transfers that no device answers. Each transfer-start strobe opens a monitoring window. If a device claims the transfer by driving one of its chip-select lines, the window closes quietly. If no chip-select appears before a programmable number of clocks has passed, the block treats the cycle as orphaned. It then drives its own one-clock transfer-acknowledge so the processor can finish the cycle, and it raises a highest-level, non-maskable interrupt request.

The interrupt, rather than a reset, keeps the machine state intact so the fault can be debugged. The block records the address of the first orphaned cycle for the handler. A sticky overflow flag shows that more orphaned cycles were released before software cleared the request. Every orphaned cycle gets its own acknowledge, so a queue of unclaimed transfers never leaves the bus stuck.

Top module: `bus_timeout_guard`

## Requirements
- R1: While reset is asserted and after it is released, the acknowledge, the interrupt request, the interrupt level, the captured address and the overflow flag are all zero.
- R2: A start strobe sampled with a non-zero limit L and no chip-select active opens a window. If no chip-select is sampled active at the next L rising edges, ack_o is high for exactly the one clock that follows the L-th edge after the start edge.
- R3: A chip-select that is sampled active at the start edge, or at any edge of the window before the timeout edge, cancels the window. No acknowledge and no interrupt follow.
- R4: A start strobe sampled while limit_i is zero is ignored: no acknowledge and no interrupt result.
- R5: The limit is captured at the start edge. Changing limit_i during the window does not move the timeout.
- R6: ack_o is never high while any chip-select line is active (chip-selects are active high, one bit per line).
- R7: A timeout sets nmi_req_o in the same clock as the acknowledge, and irq_level_o then reads 7. Both stay set until a clear strobe is sampled. irq_level_o reads 0 whenever no request is pending.
- R8: The address captured is the one on addr_i at the start edge of the first timed-out cycle. It is held unchanged while the request is pending.
- R9: A further timeout while a request is pending still yields its own acknowledge pulse and sets fault_ovf_o. It leaves the captured address unchanged.
- R10: When a clear strobe and a timeout are sampled at the same edge, the request stays set, the captured address becomes that of the new cycle and the overflow flag is cleared.
- R11: A clear strobe sampled without a timeout drops the request, clears the overflow flag and sets the captured address to zero.
- R12: A start strobe sampled while a window is open restarts the window: the count starts over and the new address is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_start_i | input | 1 | Transfer-start strobe from the processor |
| cs_i | input | NUM_CS | Chip-select lines, active high |
| addr_i | input | ADDR_W | Address bus, sampled at the start strobe |
| limit_i | input | LIMIT_W | Timeout limit in clocks; zero disables monitoring |
| irq_clr_i | input | 1 | Interrupt clear strobe from software |
| ack_o | output | 1 | Transfer-acknowledge pulse for an orphaned cycle |
| nmi_req_o | output | 1 | Pending non-maskable interrupt request |
| irq_level_o | output | 3 | Requested interrupt level (7 when pending, else 0) |
| fault_addr_o | output | ADDR_W | Address of the first orphaned cycle |
| fault_ovf_o | output | 1 | Sticky flag: another timeout occurred while pending |

## Verification
The bench builds the block with a 16-bit address, four chip-select lines and an 8-bit limit. Limits of 1 to 5 clocks keep every window short. This makes back-to-back orphaned cycles, a restart within an open window and a clear that lands on the timeout edge easy to place exactly. Four chip-select lines let the claim and masking cases drive a line other than bit 0, which exercises the reduction across the whole vector.

// File: rtl/btg_pkg.sv
package btg_pkg;

    localparam int unsigned IRQ_LVL_W = 3;
    localparam logic [IRQ_LVL_W-1:0] IRQ_LVL_NMI  = 3'd7;
    localparam logic [IRQ_LVL_W-1:0] IRQ_LVL_NONE = 3'd0;

    typedef enum logic [0:0] {
        WIN_IDLE  = 1'b0,
        WIN_WATCH = 1'b1
    } win_state_e;

endpackage

// File: rtl/btg_cs_detect.sv
module btg_cs_detect #(
    parameter int unsigned NUM_CS     = 4,
    parameter bit          CS_ACT_LOW = 1'b0
) (
    input  logic [NUM_CS-1:0] cs_i,
    output logic              cs_any_o
);

    logic [NUM_CS-1:0] cs_hit;

    // Normalise polarity so the rest of the block sees active-high selects.
    generate
        if (CS_ACT_LOW) begin : g_low
            assign cs_hit = ~cs_i;
        end else begin : g_high
            assign cs_hit = cs_i;
        end
    endgenerate

    assign cs_any_o = |cs_hit;

endmodule

// File: rtl/btg_window.sv
module btg_window
    import btg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LIMIT_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               cs_any_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               tmo_o,
    output logic [ADDR_W-1:0]  tmo_addr_o
);

    typedef struct packed {
        win_state_e         state;
        logic [LIMIT_W-1:0] cnt;
        logic [LIMIT_W-1:0] lim;
        logic [ADDR_W-1:0]  addr;
    } win_t;

    win_t win_d, win_q;
    logic tmo_d;
    logic [LIMIT_W-1:0] lim_last;
    logic limit_zero;

    assign lim_last   = win_q.lim - 1'b1;
    assign limit_zero = (limit_i == '0);

    always_comb begin
        win_d = win_q;
        tmo_d = 1'b0;

        unique case (win_q.state)
            WIN_IDLE: begin
                win_d.cnt = '0;
            end
            WIN_WATCH: begin
                if (cs_any_i) begin
                    // A device answered: the cycle is claimed.
                    win_d.state = WIN_IDLE;
                    win_d.cnt   = '0;
                end else if (win_q.cnt == lim_last) begin
                    tmo_d       = 1'b1;
                    win_d.state = WIN_IDLE;
                    win_d.cnt   = '0;
                end else begin
                    win_d.cnt = win_q.cnt + 1'b1;
                end
            end
            default: begin
                win_d.state = WIN_IDLE;
            end
        endcase

        // A new strobe opens (or restarts) a window unless it is claimed at once.
        if (start_i && !limit_zero && !cs_any_i) begin
            win_d.state = WIN_WATCH;
            win_d.cnt   = '0;
            win_d.lim   = limit_i;
            win_d.addr  = addr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q <= '{state: WIN_IDLE, cnt: '0, lim: '0, addr: '0};
        end else begin
            win_q <= win_d;
        end
    end

    assign tmo_o      = tmo_d;
    assign tmo_addr_o = win_q.addr;

endmodule

// File: rtl/btg_ack_gen.sv
module btg_ack_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tmo_i,
    input  logic cs_any_i,
    output logic ack_o
);

    typedef struct packed {
        logic ack;
    } ack_t;

    ack_t ack_d, ack_q;

    always_comb begin
        ack_d     = ack_q;
        ack_d.ack = tmo_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ack_q <= '{ack: 1'b0};
        end else begin
            ack_q <= ack_d;
        end
    end

    // Stay off the line whenever a device is driving its own select.
    assign ack_o = ack_q.ack && !cs_any_i;

endmodule

// File: rtl/btg_fault_log.sv
module btg_fault_log
    import btg_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tmo_i,
    input  logic [ADDR_W-1:0]    tmo_addr_i,
    input  logic                 clr_i,
    output logic                 pend_o,
    output logic [IRQ_LVL_W-1:0] level_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 ovf_o
);

    typedef struct packed {
        logic              pend;
        logic              ovf;
        logic [ADDR_W-1:0] addr;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;

        if (clr_i) begin
            log_d.pend = 1'b0;
            log_d.ovf  = 1'b0;
            log_d.addr = '0;
        end

        if (tmo_i) begin
            if (!log_q.pend || clr_i) begin
                log_d.pend = 1'b1;
                log_d.addr = tmo_addr_i;
            end else begin
                log_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            log_q <= '{pend: 1'b0, ovf: 1'b0, addr: '0};
        end else begin
            log_q <= log_d;
        end
    end

    assign pend_o  = log_q.pend;
    assign level_o = log_q.pend ? IRQ_LVL_NMI : IRQ_LVL_NONE;
    assign addr_o  = log_q.addr;
    assign ovf_o   = log_q.ovf;

endmodule

// File: rtl/bus_timeout_guard.sv
module bus_timeout_guard
    import btg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NUM_CS     = 6,
    parameter int unsigned LIMIT_W    = 16,
    parameter bit          CS_ACT_LOW = 1'b0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 xfer_start_i,
    input  logic [NUM_CS-1:0]    cs_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [LIMIT_W-1:0]   limit_i,
    input  logic                 irq_clr_i,
    output logic                 ack_o,
    output logic                 nmi_req_o,
    output logic [IRQ_LVL_W-1:0] irq_level_o,
    output logic [ADDR_W-1:0]    fault_addr_o,
    output logic                 fault_ovf_o
);

    logic              cs_any;
    logic              tmo_evt;
    logic [ADDR_W-1:0] tmo_addr;

    btg_cs_detect #(
        .NUM_CS     (NUM_CS),
        .CS_ACT_LOW (CS_ACT_LOW)
    ) u_cs (
        .cs_i     (cs_i),
        .cs_any_o (cs_any)
    );

    btg_window #(
        .ADDR_W  (ADDR_W),
        .LIMIT_W (LIMIT_W)
    ) u_win (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (xfer_start_i),
        .cs_any_i   (cs_any),
        .addr_i     (addr_i),
        .limit_i    (limit_i),
        .tmo_o      (tmo_evt),
        .tmo_addr_o (tmo_addr)
    );

    btg_ack_gen u_ack (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tmo_i    (tmo_evt),
        .cs_any_i (cs_any),
        .ack_o    (ack_o)
    );

    btg_fault_log #(
        .ADDR_W (ADDR_W)
    ) u_log (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tmo_i      (tmo_evt),
        .tmo_addr_i (tmo_addr),
        .clr_i      (irq_clr_i),
        .pend_o     (nmi_req_o),
        .level_o    (irq_level_o),
        .addr_o     (fault_addr_o),
        .ovf_o      (fault_ovf_o)
    );

endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_any_i,
    input logic              tmo_i,
    input logic              ack_i,
    input logic              nmi_i,
    input logic [2:0]        level_i,
    input logic              clr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ovf_i
);

    // R2: the acknowledge is a single-clock pulse
    p_ack_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> !ack_i);

    // R6: no acknowledge while a device selects
    p_no_ack_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_any_i |-> !ack_i);

    // R7: an acknowledge always comes with a pending request at level 7
    p_ack_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |-> (nmi_i && level_i == 3'd7));

    // R7: the request holds until a clear is sampled
    p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_i && !clr_i) |=> nmi_i);

    // R8: the captured address holds while pending and uncleared
    p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nmi_i && !clr_i) |=> $stable(addr_i));

    // R9: overflow only exists alongside a pending request
    p_ovf_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i |-> nmi_i);

    // R10: a timeout at the clear edge keeps the request
    p_clr_collide_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && tmo_i) |=> (nmi_i && !ovf_i));

    // R11: a lone clear drops the request
    p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !tmo_i) |=> (!nmi_i && !ovf_i));

endmodule

bind bus_timeout_guard btg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_any_i (cs_any),
    .tmo_i    (tmo_evt),
    .ack_i    (ack_o),
    .nmi_i    (nmi_req_o),
    .level_i  (irq_level_o),
    .clr_i    (irq_clr_i),
    .addr_i   (fault_addr_o),
    .ovf_i    (fault_ovf_o)
);

// File: tb/sim_bus_timeout_guard.sv
`timescale 1ns/1ps
module sim_bus_timeout_guard;

    localparam int unsigned AW = 16;
    localparam int unsigned NC = 4;
    localparam int unsigned LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer = 1'b0;
    logic [NC-1:0] cs = '0;
    logic [AW-1:0] addr = '0;
    logic [LW-1:0] limit = '0;
    logic          clr = 1'b0;
    logic          ack;
    logic          nmi;
    logic [2:0]    lvl;
    logic [AW-1:0] faddr;
    logic          ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_timeout_guard #(
        .ADDR_W (AW), .NUM_CS (NC), .LIMIT_W (LW), .CS_ACT_LOW (1'b0)
    ) u0 (
        .clk_i (clk), .rst_ni (rst_n), .xfer_start_i (xfer), .cs_i (cs),
        .addr_i (addr), .limit_i (limit), .irq_clr_i (clr),
        .ack_o (ack), .nmi_req_o (nmi), .irq_level_o (lvl),
        .fault_addr_o (faddr), .fault_ovf_o (ovf)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start_xfer(input logic [AW-1:0] a, input logic [LW-1:0] l);
        @(negedge clk);
        limit = l;
        addr  = a;
        xfer  = 1'b1;
        @(negedge clk);
        xfer  = 1'b0;
    endtask

    // Called right after start_xfer: ack low for L cycles, high for one, then low.
    task automatic expect_ack(input int l, input string tag);
        bit early = 1'b0;
        for (int i = 1; i < l; i++) begin
            @(negedge clk);
            if (ack) early = 1'b1;
        end
        check(!early, {tag, " no early ack"}, early, 0);
        @(negedge clk);
        check(ack == 1'b1, {tag, " ack on timeout"}, ack, 1);
        @(negedge clk);
        check(ack == 1'b0, {tag, " ack one clock"}, ack, 0);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        check(ack == 0 && nmi == 0 && lvl == 0 && faddr == 0 && ovf == 0,
              "R1 reset state", {ack, nmi, lvl, ovf}, 0);
    endtask

    task automatic t_basic();
        start_xfer(16'h1234, 8'd3);
        expect_ack(3, "R2");
        check(nmi == 1'b1, "R7 request set", nmi, 1);
        check(lvl == 3'd7, "R7 level 7", lvl, 7);
        check(faddr == 16'h1234, "R8 address captured", faddr, 16'h1234);
        repeat (3) @(negedge clk);
        check(nmi == 1'b1 && faddr == 16'h1234, "R8 held while pending", faddr, 16'h1234);
    endtask

    task automatic t_clear();
        pulse_clear();
        check(nmi == 0 && lvl == 0 && faddr == 0 && ovf == 0, "R11 clear", {nmi, lvl, ovf}, 0);
    endtask

    task automatic t_claim();
        bit seen = 1'b0;
        start_xfer(16'h2000, 8'd5);
        @(negedge clk);
        cs = 4'b0100;
        @(negedge clk);
        cs = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
        end
        check(!seen, "R3 claimed cycle no ack", seen, 0);
        check(nmi == 0, "R3 claimed cycle no irq", nmi, 0);
        // Select active at the start edge itself
        @(negedge clk);
        limit = 8'd2; addr = 16'h2222; xfer = 1'b1; cs = 4'b1000;
        @(negedge clk);
        xfer = 1'b0; cs = '0;
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
        end
        check(!seen && nmi == 0, "R3 claim at start edge", {seen, nmi}, 0);
    endtask

    task automatic t_zero();
        bit seen = 1'b0;
        start_xfer(16'h3000, 8'd0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
        end
        check(!seen && nmi == 0, "R4 zero limit ignored", {seen, nmi}, 0);
    endtask

    task automatic t_limit_latch();
        start_xfer(16'h4000, 8'd4);
        limit = 8'd1;
        expect_ack(4, "R5 latched limit");
        check(faddr == 16'h4000, "R5 address", faddr, 16'h4000);
        pulse_clear();
    endtask

    task automatic t_mask();
        start_xfer(16'h5000, 8'd2);
        @(negedge clk);
        @(posedge clk);
        #1 cs = 4'b0010;
        @(negedge clk);
        check(ack == 1'b0, "R6 ack masked by select", ack, 0);
        check(nmi == 1'b1, "R6 timeout still logged", nmi, 1);
        cs = '0;
        pulse_clear();
    endtask

    task automatic t_overflow();
        start_xfer(16'h6001, 8'd2);
        expect_ack(2, "R9 first");
        check(ovf == 1'b0, "R9 no overflow after first", ovf, 0);
        start_xfer(16'h6002, 8'd2);
        expect_ack(2, "R9 second acked");
        check(ovf == 1'b1, "R9 overflow set", ovf, 1);
        check(faddr == 16'h6001, "R9 address kept", faddr, 16'h6001);
        pulse_clear();
        check(nmi == 0 && ovf == 0 && faddr == 0, "R11 clear after overflow", {nmi, ovf}, 0);
    endtask

    task automatic t_collide();
        start_xfer(16'h7001, 8'd2);
        expect_ack(2, "R10 setup");
        start_xfer(16'h7002, 8'd1);
        expect_ack(1, "R10 setup2");
        check(ovf == 1'b1, "R10 overflow before collide", ovf, 1);
        start_xfer(16'h7003, 8'd2);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(ack == 1'b1, "R10 ack at collide", ack, 1);
        check(nmi == 1'b1, "R10 request kept", nmi, 1);
        check(faddr == 16'h7003, "R10 new address", faddr, 16'h7003);
        check(ovf == 1'b0, "R10 overflow cleared", ovf, 0);
        pulse_clear();
    endtask

    task automatic t_restart();
        start_xfer(16'h8001, 8'd4);
        @(negedge clk);
        addr = 16'h8002;
        xfer = 1'b1;
        @(negedge clk);
        xfer = 1'b0;
        expect_ack(4, "R12 restart");
        check(faddr == 16'h8002, "R12 new address", faddr, 16'h8002);
        pulse_clear();
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0x1 expected=0x0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_claim();
        t_zero();
        t_limit_latch();
        t_mask();
        t_overflow();
        t_collide();
        t_restart();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule